// File: doc/BRIEF.md
# Channel Mask Normalizer

This block takes a requested channel-selection word and turns it into the mask that a two-converter acquisition engine and its packet builder can actually use. Converters run in pairs, so a mask with an odd number of channels is grown to an even count, unless exactly one channel is requested. Every data packet carries a fixed 480-bit sample body. That body must hold a whole number of samples for every active channel at the selected output resolution. When it does not, the block adds two more channels at a time until it does.

Channels are always added from the lowest-numbered channels that are not yet selected. For each request the block reports three things: the effective mask, the channel count, and the number of samples per channel that fit in one packet body. The result is registered, and a one-cycle valid strobe marks each answer. A request the block cannot satisfy raises an error flag and leaves the previous answer in place.

Top module: `chmask_norm`

## Requirements
- R1: After reset, `out_valid`, `cfg_err`, `eff_mask`, `chan_count` and `pkt_spc` are all zero.
- R2: A request sampled with `req_valid` high at a rising edge produces its result at that same edge. `out_valid` is high for exactly that one following cycle and low whenever no request was sampled.
- R3: Only bits 9..0 of `req_mask` are used; bits 15..10 have no effect on any output.
- R4: An all-zero request yields mask 0, count 0, samples-per-channel 0 and `cfg_err` low.
- R5: A request with exactly one channel is kept unchanged, with count 1 and samples-per-channel equal to 480 / resolution.
- R6: A request with an odd count greater than one gains the lowest-numbered unselected channel, making the count even.
- R7: At resolution 8 with 8 channels, the two lowest-numbered unselected channels are added, giving 10 channels and 6 samples per channel.
- R8: At resolution 12 with 6 channels, the two lowest-numbered unselected channels are added, giving 8 channels and 5 samples per channel.
- R9: For every accepted non-empty request, `chan_count` equals the number of ones in `eff_mask`, `eff_mask` contains every requested channel, and `pkt_spc` × resolution × `chan_count` = 480.
- R10: A resolution code other than 2, 4, 8 or 12 (values of `req_res`) sets `cfg_err`; `eff_mask`, `chan_count` and `pkt_spc` keep their previous values.
- R11: `cfg_err` holds between requests and is cleared by the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_mask | input | 16 | Requested channel mask, bit 0 = lowest channel |
| req_res | input | 4 | Output resolution in bits per sample |
| out_valid | output | 1 | One-cycle strobe for a fresh result |
| eff_mask | output | 10 | Effective channel mask |
| chan_count | output | 4 | Number of channels in `eff_mask` |
| pkt_spc | output | 9 | Samples per channel per packet body |
| cfg_err | output | 1 | Last request was rejected |

## Verification
The bench builds the block with its default parameters: 10 channels, a 16-bit request word and a 480-bit body. Together these make both indivisible cases reachable: 8-bit with 8 channels and 12-bit with 6 channels. They also allow a chained case, where parity padding feeds into divisibility padding (7 channels becoming 10). With these sizes no legal resolution can exhaust the channels, so the rejection path is reached through illegal resolution codes. Each rejection is followed by a check that the previous mask is still presented.

// File: rtl/chmask_pkg.sv
package chmask_pkg;

   localparam int unsigned MAX_CH = 64;

   function automatic int unsigned pop_count(input logic [MAX_CH-1:0] v);
      int unsigned n;
      n = 0;
      for (int i = 0; i < MAX_CH; i++) begin
         n += {31'd0, v[i]};
      end
      return n;
   endfunction

   function automatic logic res_legal(input int unsigned r);
      return (r == 2) || (r == 4) || (r == 8) || (r == 12);
   endfunction

endpackage

// File: rtl/chmask_fill_low.sv
module chmask_fill_low #(
   parameter int unsigned N = 10
) (
   input  logic [N-1:0] in_mask,
   output logic [N-1:0] out_mask,
   output logic         full
);
   logic [N-1:0] lowest_zero;

   always_comb begin
      lowest_zero = ~in_mask & (in_mask + N'(1));
      out_mask    = in_mask | lowest_zero;
      full        = &in_mask;
   end
endmodule

// File: rtl/chmask_pad_stage.sv
module chmask_pad_stage #(
   parameter int unsigned N         = 10,
   parameter int unsigned BODY_BITS = 480,
   parameter int unsigned RES_W     = 4
) (
   input  logic [N-1:0]     in_mask,
   input  logic [RES_W-1:0] res,
   output logic [N-1:0]     out_mask,
   output logic             ovf
);
   import chmask_pkg::*;

   logic [N-1:0] first_fill;
   logic [N-1:0] second_fill;
   logic         full_a;
   logic         full_b;
   logic         need;

   chmask_fill_low #(.N(N)) u_fill_a (
      .in_mask (in_mask),
      .out_mask(first_fill),
      .full    (full_a)
   );

   chmask_fill_low #(.N(N)) u_fill_b (
      .in_mask (first_fill),
      .out_mask(second_fill),
      .full    (full_b)
   );

   always_comb begin
      int unsigned cnt;
      int unsigned prod;
      cnt  = pop_count(MAX_CH'(in_mask));
      prod = 32'(res) * cnt;
      need = (prod != 0) && ((BODY_BITS % prod) != 0);
      out_mask = need ? second_fill : in_mask;
      ovf      = need && (full_a || full_b);
   end
endmodule

// File: rtl/chmask_norm.sv
module chmask_norm #(
   parameter int unsigned NUM_CH     = 10,
   parameter int unsigned REQ_W      = 16,
   parameter int unsigned RES_W      = 4,
   parameter int unsigned BODY_BITS  = 480,
   parameter int unsigned PAD_STAGES = NUM_CH / 2,
   localparam int unsigned CNT_W     = $clog2(NUM_CH + 1),
   localparam int unsigned SPC_W     = $clog2(BODY_BITS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [REQ_W-1:0]  req_mask,
   input  logic [RES_W-1:0]  req_res,
   output logic              out_valid,
   output logic [NUM_CH-1:0] eff_mask,
   output logic [CNT_W-1:0]  chan_count,
   output logic [SPC_W-1:0]  pkt_spc,
   output logic              cfg_err
);
   import chmask_pkg::*;

   generate
      if (REQ_W < NUM_CH) begin : g_bad_req_w
         $error("chmask_norm: REQ_W must cover NUM_CH");
      end
      if (NUM_CH > MAX_CH || NUM_CH < 2) begin : g_bad_num_ch
         $error("chmask_norm: NUM_CH out of supported range");
      end
      if (PAD_STAGES < 1) begin : g_bad_stages
         $error("chmask_norm: PAD_STAGES must be at least 1");
      end
   endgenerate

   // ---------------- parity stage ----------------
   logic [NUM_CH-1:0] raw_mask;
   logic [NUM_CH-1:0] par_fill;
   logic              par_full;
   logic              par_need;

   assign raw_mask = req_mask[NUM_CH-1:0];

   chmask_fill_low #(.N(NUM_CH)) u_par_fill (
      .in_mask (raw_mask),
      .out_mask(par_fill),
      .full    (par_full)
   );

   always_comb begin
      int unsigned n0;
      n0       = pop_count(MAX_CH'(raw_mask));
      par_need = (n0 > 1) && (n0 % 2 == 1);
   end

   // ---------------- divisibility chain ----------------
   logic [NUM_CH-1:0] chain [PAD_STAGES+1];
   logic [PAD_STAGES:0] ovf_v;

   assign chain[0] = par_need ? par_fill : raw_mask;
   assign ovf_v[0] = par_need && par_full;

   generate
      for (genvar s = 0; s < PAD_STAGES; s++) begin : g_pad
         chmask_pad_stage #(
            .N        (NUM_CH),
            .BODY_BITS(BODY_BITS),
            .RES_W    (RES_W)
         ) u_stage (
            .in_mask (chain[s]),
            .res     (req_res),
            .out_mask(chain[s+1]),
            .ovf     (ovf_v[s+1])
         );
      end
   endgenerate

   // ---------------- final evaluation ----------------
   logic [NUM_CH-1:0] fin_mask;
   logic [CNT_W-1:0]  fin_cnt;
   logic [SPC_W-1:0]  fin_spc;
   logic              fin_err;

   always_comb begin
      int unsigned cnt;
      int unsigned prod;
      fin_mask = chain[PAD_STAGES];
      cnt      = pop_count(MAX_CH'(fin_mask));
      prod     = 32'(req_res) * cnt;
      fin_cnt  = CNT_W'(cnt);
      fin_spc  = (prod == 0) ? '0 : SPC_W'(BODY_BITS / prod);
      fin_err  = !res_legal(32'(req_res)) || (|ovf_v)
                 || ((prod != 0) && ((BODY_BITS % prod) != 0));
   end

   // ---------------- output register ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         eff_mask   <= '0;
         chan_count <= '0;
         pkt_spc    <= '0;
         cfg_err    <= 1'b0;
      end else begin
         out_valid <= req_valid;
         if (req_valid) begin
            cfg_err <= fin_err;
            if (!fin_err) begin
               eff_mask   <= fin_mask;
               chan_count <= fin_cnt;
               pkt_spc    <= fin_spc;
            end
         end
      end
   end

   // ---------------- assertions ----------------
   // R2
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> out_valid);
   // R2
   valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !out_valid);
   // R10
   err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && cfg_err) |-> ($stable(eff_mask) && $stable(chan_count) && $stable(pkt_spc)));
   // R11
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> $stable(cfg_err));
   // R9
   superset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !fin_err) |=> ((eff_mask & $past(raw_mask)) == $past(raw_mask)));
   // R9
   count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(eff_mask) == 32'(chan_count));
   // R6
   even_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !cfg_err && chan_count > 1) |-> (chan_count[0] == 1'b0));
   // R9
   body_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !cfg_err && chan_count != 0)
      |-> ((32'(pkt_spc) * 32'($past(req_res)) * 32'(chan_count)) == BODY_BITS));

endmodule

// File: tb/chmask_norm_bench.sv
module chmask_norm_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic [15:0] req_mask;
   logic [3:0]  req_res;
   logic        out_valid;
   logic [9:0]  eff_mask;
   logic [3:0]  chan_count;
   logic [8:0]  pkt_spc;
   logic        cfg_err;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   chmask_norm u_chmask_norm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_mask  (req_mask),
      .req_res   (req_res),
      .out_valid (out_valid),
      .eff_mask  (eff_mask),
      .chan_count(chan_count),
      .pkt_spc   (pkt_spc),
      .cfg_err   (cfg_err)
   );

   task automatic check(input string tag, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, got, exp);
      end
   endtask

   // drive one request, sample the registered answer one edge later
   task automatic request(input logic [15:0] m, input logic [3:0] r);
      @(negedge clk);
      req_mask  = m;
      req_res   = r;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic expect_ok(input string tag, input int m, input int c, input int s);
      check({tag, " valid"}, int'(out_valid), 1);
      check({tag, " err"},   int'(cfg_err), 0);
      check({tag, " mask"},  int'(eff_mask), m);
      check({tag, " count"}, int'(chan_count), c);
      check({tag, " spc"},   int'(pkt_spc), s);
   endtask

   task automatic t_reset();
      check("R1 valid", int'(out_valid), 0);
      check("R1 err",   int'(cfg_err), 0);
      check("R1 mask",  int'(eff_mask), 0);
      check("R1 count", int'(chan_count), 0);
      check("R1 spc",   int'(pkt_spc), 0);
   endtask

   task automatic t_strobe();
      request(16'h0003, 4'd2);
      check("R2 valid high", int'(out_valid), 1);
      @(negedge clk);
      check("R2 valid low", int'(out_valid), 0);
      check("R2 mask held", int'(eff_mask), 'h003);
   endtask

   task automatic t_upper_ignored();
      request(16'hFC01, 4'd8);
      expect_ok("R3", 'h001, 1, 60);
   endtask

   task automatic t_empty();
      request(16'h0000, 4'd12);
      expect_ok("R4", 0, 0, 0);
   endtask

   task automatic t_single();
      request(16'h0200, 4'd2);
      expect_ok("R5 ch9 res2", 'h200, 1, 240);
      request(16'h0010, 4'd12);
      expect_ok("R5 ch4 res12", 'h010, 1, 40);
   endtask

   task automatic t_odd();
      request(16'h0016, 4'd4);
      expect_ok("R6 three", 'h017, 4, 30);
      request(16'h03FE, 4'd2);
      expect_ok("R6 nine", 'h3FF, 10, 24);
   endtask

   task automatic t_eight_at_8();
      request(16'h00FF, 4'd8);
      expect_ok("R7 low8", 'h3FF, 10, 6);
      request(16'h02B7, 4'd8);
      expect_ok("R7 seven chained", 'h3FF, 10, 6);
   endtask

   task automatic t_six_at_12();
      request(16'h003F, 4'd12);
      expect_ok("R8 low6", 'h0FF, 8, 5);
      request(16'h0155, 4'd12);
      expect_ok("R8 five chained", 'h17F, 8, 5);
   endtask

   task automatic t_general();
      request(16'h000C, 4'd12);
      expect_ok("R9 two res12", 'h00C, 2, 20);
      request(16'h00FF, 4'd4);
      expect_ok("R9 eight res4", 'h0FF, 8, 15);
      request(16'h0300, 4'd8);
      expect_ok("R9 two res8", 'h300, 2, 30);
   endtask

   task automatic t_bad_res();
      request(16'h0155, 4'd12);
      expect_ok("R10 setup", 'h17F, 8, 5);
      request(16'h0003, 4'd6);
      check("R10 err res6", int'(cfg_err), 1);
      check("R10 valid", int'(out_valid), 1);
      check("R10 mask held", int'(eff_mask), 'h17F);
      check("R10 count held", int'(chan_count), 8);
      check("R10 spc held", int'(pkt_spc), 5);
      request(16'h0001, 4'd0);
      check("R10 err res0", int'(cfg_err), 1);
      check("R10 mask held res0", int'(eff_mask), 'h17F);
   endtask

   task automatic t_err_clear();
      repeat (3) @(negedge clk);
      check("R11 err sticky", int'(cfg_err), 1);
      request(16'h0003, 4'd4);
      expect_ok("R11 cleared", 'h003, 2, 60);
   endtask

   initial begin
      rst_n     = 1'b0;
      req_valid = 1'b0;
      req_mask  = '0;
      req_res   = 4'd8;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_strobe();
      t_upper_ignored();
      t_empty();
      t_single();
      t_odd();
      t_eight_at_8();
      t_six_at_12();
      t_general();
      t_bad_res();
      t_err_clear();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule